// File: doc/BRIEF.md
# Texel Unpack and Component Select

This block turns one raw fetched word, up to 128 bits wide, into four 32-bit destination components named X, Y, Z and W. A 4-bit layout code tells it how many packed fields the word holds and how wide each one is. Fields are taken from bit 0 upward. A 3-bit number-kind code then tells it how to turn each field into a 32-bit value: zero-extended or sign-extended integer, normalized float, scaled float, or raw float bits.

Each destination has a 3-bit select code. The code chooses constant zero, constant one, or one of the four converted source components. An identity input overrides the select codes, so that each destination takes the matching source component. An out-of-range flag forces all four outputs to zero.

The block has one register stage. A request presented with `in_valid` high at one rising edge appears on the outputs after that edge. Between requests the outputs hold their last value.

Top module: `texel_unpack_sel`

## Requirements
- R1: While reset is held and until the first accepted request, `out_valid` is 0 and all four outputs are 0.
- R2: `out_valid` is high for exactly the cycle after each edge where `in_valid` was high. Outputs change only after an edge with `in_valid` high, and hold their value otherwise.
- R3: Fields are packed from bit 0 upward, component 0 first. The field widths for each layout code are:
  - 1: 8
  - 2: 16
  - 3: 8,8
  - 4: 32
  - 5: 16,16
  - 6: 11,11,10
  - 7: 10,11,11
  - 8: 2,10,10,10
  - 9: 10,10,10,2
  - 10: 8,8,8,8
  - 11: 32,32
  - 12: 16,16,16,16
  - 13: 32,32,32
  - 14: 32,32,32,32
- R4: Number kind 4 zero-extends each field to 32 bits. Number kind 5 sign-extends each field from its top bit.
- R5: A component that the layout does not contain reads as 0. The exception is a missing component 3, which reads as one: 32'h3F800000 for number kinds 0,1,2,3,6,7 and integer 1 for kinds 4 and 5.
- R6: The select codes sit in `in_sel`: X in bits 2:0, Y in 5:3, Z in 8:6, W in 11:9. Their meanings are:
  - 0: constant zero
  - 1: constant one, encoded as in R5
  - 2 and 3: zero
  - 4 to 7: source components 0 to 3
- R7: With `in_identity` = 1, `in_sel` has no effect and destination i takes source component i.
- R8: With `in_oob` = 1, all four outputs are 0 whatever the other inputs are.
- R9: Number kind 0 outputs the single-precision value of f/(2^n-1), rounded to nearest even, where f is the unsigned field and n is its width.
- R10: Number kind 1 outputs the single-precision value of s/(2^(n-1)-1), rounded to nearest even, where s is the signed field. The most negative code gives exactly -1.0.
- R11: Number kind 6 outputs the single-precision value of (2s+1)/(2^n-1), rounded to nearest even.
- R12: Number kinds 2 and 3 output the field as a single-precision value, rounded to nearest even. Kind 2 reads the field as unsigned and kind 3 reads it as signed.
- R13: Number kind 7 passes the 32 field bits through unchanged for layouts 4, 11, 13 and 14. With any other layout, all four outputs are 0.
- R14: Layout codes 0 and 15 produce 0 on all four outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_word | input | 128 | Raw fetched word |
| in_dfmt | input | 4 | Layout code |
| in_nfmt | input | 3 | Number kind code |
| in_sel | input | 12 | Four destination select codes |
| in_identity | input | 1 | Ignore select codes, route straight through |
| in_oob | input | 1 | Request is out of range, output zero |
| out_valid | output | 1 | Outputs updated by the previous edge |
| out_x | output | 32 | Destination X |
| out_y | output | 32 | Destination Y |
| out_z | output | 32 | Destination Z |
| out_w | output | 32 | Destination W |

## Verification
Out-of-range forcing and the constant-one path can both act in the same cycle, so the bench provokes them together. It sends `in_oob` high while a select code asks for constant one. It also sends `in_oob` high with a one-field layout, where the missing component 3 would otherwise default to one. Every output must read zero in both cases, which shows the forcing takes priority over both sources of one. The same pairing is tried with identity routing, and with a kind-7 request on a layout that is not 32 bits wide, where two independent zeroing conditions meet.

// File: rtl/texu_pkg.sv
package texu_pkg;

    localparam int COMP_W = 32;
    localparam int N_COMP = 4;
    localparam int WORD_W = 128;
    localparam int DFMT_W = 4;
    localparam int NFMT_W = 3;
    localparam int SEL_W  = 3;
    localparam int WID_W  = 6;
    localparam int FIX_W  = 72;
    localparam int FRAC_RATIO = 64;
    localparam int BUS_W  = N_COMP * COMP_W;

    localparam logic [COMP_W-1:0] F32_ONE     = 32'h3F80_0000;
    localparam logic [COMP_W-1:0] F32_NEG_ONE = 32'hBF80_0000;

    typedef enum logic [NFMT_W-1:0] {
        NUM_UNORM    = 3'd0,
        NUM_SNORM    = 3'd1,
        NUM_USCALED  = 3'd2,
        NUM_SSCALED  = 3'd3,
        NUM_UINT     = 3'd4,
        NUM_SINT     = 3'd5,
        NUM_SNORM_GL = 3'd6,
        NUM_FLOAT    = 3'd7
    } num_kind_e;

    typedef enum logic [SEL_W-1:0] {
        PICK_ZERO = 3'd0,
        PICK_ONE  = 3'd1,
        PICK_RSV2 = 3'd2,
        PICK_RSV3 = 3'd3,
        PICK_C0   = 3'd4,
        PICK_C1   = 3'd5,
        PICK_C2   = 3'd6,
        PICK_C3   = 3'd7
    } pick_e;

    typedef struct packed {
        logic             vld;
        logic [BUS_W-1:0] lanes;
    } texu_out_t;

    // Widths of all four fields for a layout code, component 0 in the low slot.
    function automatic logic [N_COMP*WID_W-1:0] layout_widths(logic [DFMT_W-1:0] fmt);
        logic [N_COMP*WID_W-1:0] w;
        case (fmt)
            4'd1:    w = {6'd0,  6'd0,  6'd0,  6'd8};
            4'd2:    w = {6'd0,  6'd0,  6'd0,  6'd16};
            4'd3:    w = {6'd0,  6'd0,  6'd8,  6'd8};
            4'd4:    w = {6'd0,  6'd0,  6'd0,  6'd32};
            4'd5:    w = {6'd0,  6'd0,  6'd16, 6'd16};
            4'd6:    w = {6'd0,  6'd10, 6'd11, 6'd11};
            4'd7:    w = {6'd0,  6'd11, 6'd11, 6'd10};
            4'd8:    w = {6'd10, 6'd10, 6'd10, 6'd2};
            4'd9:    w = {6'd2,  6'd10, 6'd10, 6'd10};
            4'd10:   w = {6'd8,  6'd8,  6'd8,  6'd8};
            4'd11:   w = {6'd0,  6'd0,  6'd32, 6'd32};
            4'd12:   w = {6'd16, 6'd16, 6'd16, 6'd16};
            4'd13:   w = {6'd0,  6'd32, 6'd32, 6'd32};
            4'd14:   w = {6'd32, 6'd32, 6'd32, 6'd32};
            default: w = '0;
        endcase
        return w;
    endfunction

    function automatic logic layout_is_dword(logic [DFMT_W-1:0] fmt);
        return (fmt == 4'd4) || (fmt == 4'd11) || (fmt == 4'd13) || (fmt == 4'd14);
    endfunction

    function automatic logic layout_is_valid(logic [DFMT_W-1:0] fmt);
        return (fmt != 4'd0) && (fmt != 4'd15);
    endfunction

    function automatic logic [COMP_W-1:0] one_for(logic [NFMT_W-1:0] nfmt);
        return ((nfmt == NUM_UINT) || (nfmt == NUM_SINT)) ? 32'd1 : F32_ONE;
    endfunction

    // Round a fixed-point magnitude m / 2^frac to single precision, nearest even.
    function automatic logic [COMP_W-1:0] f32_from_fixed(logic [FIX_W-1:0] m, int frac,
                                                         logic sticky_in, logic neg);
        int               lead;
        int               expo;
        logic [FIX_W-1:0] mn;
        logic [22:0]      mant;
        logic             guard;
        logic             sticky;
        logic             carry;
        lead = -1;
        for (int i = 0; i < FIX_W; i++) begin
            if (m[i]) lead = i;
        end
        if (lead < 0) return '0;
        mn     = m << (FIX_W - 1 - lead);
        mant   = mn[FIX_W-2 -: 23];
        guard  = mn[FIX_W-25];
        sticky = (|mn[FIX_W-26:0]) | sticky_in;
        expo   = lead - frac + 127;
        {carry, mant} = {1'b0, mant} + 24'(guard & (sticky | mant[0]));
        if (carry) expo = expo + 1;
        return {neg, 8'(expo), mant};
    endfunction

    // Single-precision value of num/den (num <= den, den != 0).
    function automatic logic [COMP_W-1:0] f32_ratio(logic [COMP_W-1:0] num,
                                                    logic [COMP_W-1:0] den, logic neg);
        logic [95:0]      dvd;
        logic [95:0]      dsr;
        logic [FIX_W-1:0] quo;
        logic             rem_nz;
        dvd    = {num, 64'd0};
        dsr    = {64'd0, den};
        quo    = FIX_W'(dvd / dsr);
        rem_nz = ((dvd % dsr) != 96'd0);
        return f32_from_fixed(quo, FRAC_RATIO, rem_nz, neg);
    endfunction

endpackage

// File: rtl/texu_field_unpack.sv
module texu_field_unpack
    import texu_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [DFMT_W-1:0] dfmt_i,
    output logic [COMP_W-1:0] field_o,
    output logic [WID_W-1:0]  width_o
);

    localparam int OFF_W = $clog2(WORD_W) + 1;

    logic [N_COMP*WID_W-1:0] widths;
    logic [OFF_W-1:0]        offset;
    logic [COMP_W-1:0]       mask;

    always_comb begin
        widths  = layout_widths(dfmt_i);
        width_o = widths[LANE*WID_W +: WID_W];
        offset  = '0;
        for (int j = 0; j < LANE; j++) begin
            offset = offset + OFF_W'(widths[j*WID_W +: WID_W]);
        end
        mask    = (width_o >= WID_W'(COMP_W)) ? '1 : ((32'd1 << width_o) - 32'd1);
        field_o = COMP_W'(word_i >> offset) & mask;
    end

endmodule

// File: rtl/texu_num_convert.sv
module texu_num_convert
    import texu_pkg::*;
#(
    parameter bit LAST_IS_ONE = 1'b0
) (
    input  logic [COMP_W-1:0] field_i,
    input  logic [WID_W-1:0]  width_i,
    input  logic [NFMT_W-1:0] nfmt_i,
    output logic [COMP_W-1:0] value_o
);

    logic              msb;
    logic [COMP_W:0]   sx;
    logic [COMP_W-1:0] smag;
    logic [COMP_W-1:0] umax;
    logic [COMP_W-1:0] smax;
    logic [COMP_W-1:0] min_code;
    logic [COMP_W-1:0] gmag;
    logic [COMP_W-1:0] num_r;
    logic [COMP_W-1:0] den_r;
    logic              neg_r;
    logic [COMP_W-1:0] ratio;
    logic              neg_s;
    logic [COMP_W-1:0] scaled;

    always_comb begin
        msb = 1'b0;
        if (width_i != '0) msb = field_i[5'(width_i - 6'd1)];
        sx       = {1'b0, field_i} - (msb ? (33'd1 << width_i) : 33'd0);
        smag     = msb ? COMP_W'(33'd0 - sx) : field_i;
        umax     = (32'd1 << width_i) - 32'd1;
        smax     = umax >> 1;
        min_code = (width_i != '0) ? (32'd1 << 5'(width_i - 6'd1)) : '0;
        gmag     = msb ? COMP_W'({smag, 1'b0} - 33'd1) : COMP_W'({field_i, 1'b0} + 33'd1);

        num_r = field_i;
        den_r = umax;
        neg_r = 1'b0;
        if (nfmt_i == NUM_SNORM) begin
            num_r = smag;
            den_r = smax;
            neg_r = msb;
        end else if (nfmt_i == NUM_SNORM_GL) begin
            num_r = gmag;
            neg_r = msb;
        end
        if (den_r == '0) den_r = 32'd1;
        ratio = f32_ratio(num_r, den_r, neg_r);

        neg_s  = msb && (nfmt_i == NUM_SSCALED);
        scaled = f32_from_fixed(FIX_W'(neg_s ? smag : field_i), 0, 1'b0, neg_s);

        if (width_i == '0) begin
            value_o = LAST_IS_ONE ? one_for(nfmt_i) : '0;
        end else begin
            case (num_kind_e'(nfmt_i))
                NUM_UINT:     value_o = field_i;
                NUM_SINT:     value_o = sx[COMP_W-1:0];
                NUM_USCALED,
                NUM_SSCALED:  value_o = scaled;
                NUM_SNORM:    value_o = (msb && field_i == min_code) ? F32_NEG_ONE : ratio;
                NUM_FLOAT:    value_o = field_i;
                default:      value_o = ratio;
            endcase
        end
    end

    always_comb begin
        if (nfmt_i == NUM_UINT && width_i != '0 && width_i < WID_W'(COMP_W)) begin
            p_uint_zext_r4: assert ((value_o >> width_i) == '0)
                else $error("unsigned field leaked above its width");
        end
        if (nfmt_i == NUM_UNORM && width_i != '0) begin
            p_unorm_range_r9: assert (value_o <= F32_ONE)
                else $error("unsigned normalized value above one");
        end
        if ((nfmt_i == NUM_SNORM || nfmt_i == NUM_SNORM_GL) && width_i != '0) begin
            p_snorm_bound_r10: assert (value_o[COMP_W-2:0] <= F32_ONE[COMP_W-2:0])
                else $error("signed normalized magnitude above one");
        end
    end

endmodule

// File: rtl/texu_dst_route.sv
module texu_dst_route
    import texu_pkg::*;
(
    input  logic [BUS_W-1:0]        comp_i,
    input  logic [N_COMP*SEL_W-1:0] sel_i,
    input  logic                    identity_i,
    input  logic [COMP_W-1:0]       one_i,
    output logic [BUS_W-1:0]        dst_o
);

    for (genvar g = 0; g < N_COMP; g++) begin : g_dst
        logic [SEL_W-1:0] code;
        always_comb begin
            code = identity_i ? (SEL_W'(PICK_C0) + SEL_W'(g)) : sel_i[g*SEL_W +: SEL_W];
            case (pick_e'(code))
                PICK_ONE: dst_o[g*COMP_W +: COMP_W] = one_i;
                PICK_C0:  dst_o[g*COMP_W +: COMP_W] = comp_i[0*COMP_W +: COMP_W];
                PICK_C1:  dst_o[g*COMP_W +: COMP_W] = comp_i[1*COMP_W +: COMP_W];
                PICK_C2:  dst_o[g*COMP_W +: COMP_W] = comp_i[2*COMP_W +: COMP_W];
                PICK_C3:  dst_o[g*COMP_W +: COMP_W] = comp_i[3*COMP_W +: COMP_W];
                default:  dst_o[g*COMP_W +: COMP_W] = '0;
            endcase
        end
    end

endmodule

// File: rtl/texel_unpack_sel.sv
module texel_unpack_sel
    import texu_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [WORD_W-1:0]       in_word,
    input  logic [DFMT_W-1:0]       in_dfmt,
    input  logic [NFMT_W-1:0]       in_nfmt,
    input  logic [N_COMP*SEL_W-1:0] in_sel,
    input  logic                    in_identity,
    input  logic                    in_oob,
    output logic                    out_valid,
    output logic [COMP_W-1:0]       out_x,
    output logic [COMP_W-1:0]       out_y,
    output logic [COMP_W-1:0]       out_z,
    output logic [COMP_W-1:0]       out_w
);

    logic [BUS_W-1:0] conv_bus;
    logic [BUS_W-1:0] routed;
    logic             kill;
    texu_out_t        cur_q;
    texu_out_t        nxt_d;

    for (genvar g = 0; g < N_COMP; g++) begin : g_lane
        logic [COMP_W-1:0] fld;
        logic [WID_W-1:0]  wid;
        texu_field_unpack #(.LANE(g)) u_unpack (
            .word_i  (in_word),
            .dfmt_i  (in_dfmt),
            .field_o (fld),
            .width_o (wid)
        );
        texu_num_convert #(.LAST_IS_ONE(g == N_COMP - 1)) u_convert (
            .field_i (fld),
            .width_i (wid),
            .nfmt_i  (in_nfmt),
            .value_o (conv_bus[g*COMP_W +: COMP_W])
        );
    end

    texu_dst_route u_route (
        .comp_i     (conv_bus),
        .sel_i      (in_sel),
        .identity_i (in_identity),
        .one_i      (one_for(in_nfmt)),
        .dst_o      (routed)
    );

    always_comb begin
        kill = in_oob || !layout_is_valid(in_dfmt)
            || (in_nfmt == NUM_FLOAT && !layout_is_dword(in_dfmt));
        nxt_d     = cur_q;
        nxt_d.vld = in_valid;
        if (in_valid) nxt_d.lanes = kill ? '0 : routed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign out_valid = cur_q.vld;
    assign out_x     = cur_q.lanes[0*COMP_W +: COMP_W];
    assign out_y     = cur_q.lanes[1*COMP_W +: COMP_W];
    assign out_z     = cur_q.lanes[2*COMP_W +: COMP_W];
    assign out_w     = cur_q.lanes[3*COMP_W +: COMP_W];

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid)
        else $error("valid request not reported");

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable({out_x, out_y, out_z, out_w})))
        else $error("outputs moved without a request");

    p_oob_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_oob) |=> ({out_x, out_y, out_z, out_w} == '0))
        else $error("out-of-range request gave nonzero data");

    p_bad_layout_zero_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_dfmt == 4'd0 || in_dfmt == 4'd15)) |=> ({out_x, out_y, out_z, out_w} == '0))
        else $error("invalid layout gave nonzero data");

endmodule

// File: tb/texel_unpack_sel_tb_top.sv
`timescale 1ns/1ps
module texel_unpack_sel_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_word = '0;
    logic [3:0]   in_dfmt = '0;
    logic [2:0]   in_nfmt = '0;
    logic [11:0]  in_sel = '0;
    logic         in_identity = 1'b0;
    logic         in_oob = 1'b0;
    logic         out_valid;
    logic [31:0]  out_x, out_y, out_z, out_w;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    localparam logic [31:0] ONE_F = 32'h3F80_0000;
    localparam logic [31:0] MONE_F = 32'hBF80_0000;

    always #10 clk = ~clk;

    texel_unpack_sel dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_dfmt(in_dfmt), .in_nfmt(in_nfmt), .in_sel(in_sel),
        .in_identity(in_identity), .in_oob(in_oob), .out_valid(out_valid),
        .out_x(out_x), .out_y(out_y), .out_z(out_z), .out_w(out_w)
    );

    function automatic logic [31:0] to_f32(real r);
        logic [63:0] b;
        int          e;
        logic [22:0] m;
        logic        c;
        if (r == 0.0) return 32'd0;
        b = $realtobits(r);
        e = int'(b[62:52]) - 1023 + 127;
        m = b[51:29];
        if (b[28] && ((|b[27:0]) || m[0])) begin
            {c, m} = {1'b0, m} + 24'd1;
            if (c) e = e + 1;
        end
        return {b[63], e[7:0], m};
    endfunction

    function automatic logic [11:0] mk_sel(logic [2:0] x, logic [2:0] y, logic [2:0] z, logic [2:0] w);
        return {w, z, y, x};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check4(string req, logic [31:0] ex, logic [31:0] ey, logic [31:0] ez, logic [31:0] ew);
        check(req, "x", out_x, ex);
        check(req, "y", out_y, ey);
        check(req, "z", out_z, ez);
        check(req, "w", out_w, ew);
    endtask

    task automatic apply(logic [127:0] word, logic [3:0] dfmt, logic [2:0] nfmt,
                         logic [11:0] sel, logic ident, logic oob);
        in_word = word; in_dfmt = dfmt; in_nfmt = nfmt;
        in_sel = sel; in_identity = ident; in_oob = oob;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1", "valid", {31'd0, out_valid}, 32'd0);
        check4("R1", 0, 0, 0, 0);
    endtask

    task automatic t_layouts;
        logic [31:0] w;
        w = 32'hDEAD_BEEF;
        apply({96'd0, 32'h4433_2211}, 4'd10, 3'd4, 12'd0, 1'b1, 1'b0);
        check4("R3", 32'h11, 32'h22, 32'h33, 32'h44);
        apply({96'd0, w}, 4'd6, 3'd4, 12'd0, 1'b1, 1'b0);
        check4("R3", {21'd0, w[10:0]}, {21'd0, w[21:11]}, {22'd0, w[31:22]}, 32'd1);
        apply({96'd0, w}, 4'd7, 3'd4, 12'd0, 1'b1, 1'b0);
        check4("R3", {22'd0, w[9:0]}, {21'd0, w[20:10]}, {21'd0, w[31:21]}, 32'd1);
        apply({96'd0, w}, 4'd8, 3'd4, 12'd0, 1'b1, 1'b0);
        check4("R3", {30'd0, w[1:0]}, {22'd0, w[11:2]}, {22'd0, w[21:12]}, {22'd0, w[31:22]});
        apply({96'd0, w}, 4'd9, 3'd4, 12'd0, 1'b1, 1'b0);
        check4("R3", {22'd0, w[9:0]}, {22'd0, w[19:10]}, {22'd0, w[29:20]}, {30'd0, w[31:30]});
        apply({64'd0, 64'h8888_7777_6666_5555}, 4'd12, 3'd4, 12'd0, 1'b1, 1'b0);
        check4("R3", 32'h5555, 32'h6666, 32'h7777, 32'h8888);
        apply(128'hDDDD_DDDD_CCCC_CCCC_BBBB_BBBB_AAAA_AAAA, 4'd14, 3'd4, 12'd0, 1'b1, 1'b0);
        check4("R3", 32'hAAAA_AAAA, 32'hBBBB_BBBB, 32'hCCCC_CCCC, 32'hDDDD_DDDD);
        apply(128'hDDDD_DDDD_CCCC_CCCC_BBBB_BBBB_AAAA_AAAA, 4'd13, 3'd4, 12'd0, 1'b1, 1'b0);
        check4("R3", 32'hAAAA_AAAA, 32'hBBBB_BBBB, 32'hCCCC_CCCC, 32'd1);
        apply(128'hDDDD_DDDD_CCCC_CCCC_BBBB_BBBB_AAAA_AAAA, 4'd11, 3'd4, 12'd0, 1'b1, 1'b0);
        check4("R3", 32'hAAAA_AAAA, 32'hBBBB_BBBB, 32'd0, 32'd1);
        apply({96'd0, 32'h1234_5678}, 4'd5, 3'd4, 12'd0, 1'b1, 1'b0);
        check4("R3", 32'h5678, 32'h1234, 32'd0, 32'd1);
        apply({96'd0, 32'h1234_5678}, 4'd3, 3'd4, 12'd0, 1'b1, 1'b0);
        check4("R3", 32'h78, 32'h56, 32'd0, 32'd1);
    endtask

    task automatic t_sign_ext;
        apply({96'd0, 32'h8001_7FFF}, 4'd5, 3'd5, 12'd0, 1'b1, 1'b0);
        check4("R4", 32'h0000_7FFF, 32'hFFFF_8001, 32'd0, 32'd1);
        apply({96'd0, 2'b10, 30'd0}, 4'd9, 3'd5, 12'd0, 1'b1, 1'b0);
        check("R4", "w 2-bit signed", out_w, 32'hFFFF_FFFE);
        apply({96'd0, 30'd0, 2'b11}, 4'd8, 3'd5, 12'd0, 1'b1, 1'b0);
        check("R4", "x 2-bit signed", out_x, 32'hFFFF_FFFF);
        apply({96'd0, 32'hFFFF_FFFF}, 4'd8, 3'd4, 12'd0, 1'b1, 1'b0);
        check4("R4", 32'd3, 32'h3FF, 32'h3FF, 32'h3FF);
    endtask

    task automatic t_missing;
        apply({96'd0, 32'hFFFF_FFFF}, 4'd1, 3'd0, 12'd0, 1'b1, 1'b0);
        check4("R5", ONE_F, 32'd0, 32'd0, ONE_F);
        apply({96'd0, 32'hFFFF_FFFF}, 4'd3, 3'd5, 12'd0, 1'b1, 1'b0);
        check4("R5", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'd1);
    endtask

    task automatic t_select;
        apply({96'd0, 32'h4433_2211}, 4'd10, 3'd4, mk_sel(3'd7, 3'd0, 3'd1, 3'd4), 1'b0, 1'b0);
        check4("R6", 32'h44, 32'd0, 32'd1, 32'h11);
        apply({96'd0, 32'h4433_2211}, 4'd10, 3'd4, mk_sel(3'd5, 3'd6, 3'd2, 3'd3), 1'b0, 1'b0);
        check4("R6", 32'h22, 32'h33, 32'd0, 32'd0);
        apply({96'd0, 32'hFF00_00FF}, 4'd10, 3'd0, mk_sel(3'd1, 3'd4, 3'd5, 3'd0), 1'b0, 1'b0);
        check4("R6", ONE_F, ONE_F, 32'd0, 32'd0);
    endtask

    task automatic t_identity;
        apply({96'd0, 32'h4433_2211}, 4'd10, 3'd4, mk_sel(3'd7, 3'd0, 3'd1, 3'd4), 1'b1, 1'b0);
        check4("R7", 32'h11, 32'h22, 32'h33, 32'h44);
    endtask

    task automatic t_oob;
        apply({96'd0, 32'h4433_2211}, 4'd10, 3'd4, mk_sel(3'd1, 3'd1, 3'd4, 3'd1), 1'b0, 1'b1);
        check4("R8 with constant one", 0, 0, 0, 0);
        apply({96'd0, 32'hFF}, 4'd1, 3'd0, 12'd0, 1'b1, 1'b1);
        check4("R8 with missing w", 0, 0, 0, 0);
        apply({96'd0, 32'h8}, 4'd10, 3'd7, 12'd0, 1'b1, 1'b1);
        check4("R8 with bad float", 0, 0, 0, 0);
    endtask

    task automatic t_unorm;
        apply({96'd0, 8'd128, 8'd0, 8'd255, 8'd1}, 4'd10, 3'd0, 12'd0, 1'b1, 1'b0);
        check4("R9", to_f32(1.0/255.0), ONE_F, 32'd0, to_f32(128.0/255.0));
        apply({64'd0, 16'd1, 16'd12345, 16'h8000, 16'hFFFF}, 4'd12, 3'd0, 12'd0, 1'b1, 1'b0);
        check4("R9", ONE_F, to_f32(32768.0/65535.0), to_f32(12345.0/65535.0), to_f32(1.0/65535.0));
        apply({96'd0, 32'h8000_0000}, 4'd4, 3'd0, 12'd0, 1'b1, 1'b0);
        check("R9", "32-bit", out_x, to_f32(2147483648.0/4294967295.0));
    endtask

    task automatic t_snorm;
        apply({96'd0, 8'h40, 8'h7F, 8'h81, 8'h80}, 4'd10, 3'd1, 12'd0, 1'b1, 1'b0);
        check4("R10", MONE_F, MONE_F, ONE_F, to_f32(64.0/127.0));
        apply({96'd0, 22'd0, 10'h3FF}, 4'd7, 3'd1, 12'd0, 1'b1, 1'b0);
        check("R10", "10-bit -1", out_x, to_f32(-1.0/511.0));
        apply({96'd0, 30'd0, 2'b10}, 4'd8, 3'd1, 12'd0, 1'b1, 1'b0);
        check("R10", "2-bit min", out_x, MONE_F);
        apply({96'd0, 30'd0, 2'b01}, 4'd8, 3'd1, 12'd0, 1'b1, 1'b0);
        check("R10", "2-bit max", out_x, ONE_F);
    endtask

    task automatic t_snorm_gl;
        apply({96'd0, 8'hFF, 8'h00, 8'h7F, 8'h80}, 4'd10, 3'd6, 12'd0, 1'b1, 1'b0);
        check4("R11", MONE_F, ONE_F, to_f32(1.0/255.0), to_f32(-1.0/255.0));
    endtask

    task automatic t_scaled;
        apply({32'd0, 32'h0100_0003, 32'h0100_0001, 32'hFFFF_FFFF}, 4'd14, 3'd2, 12'd0, 1'b1, 1'b0);
        check4("R12", 32'h4F80_0000, 32'h4B80_0000, to_f32(16777219.0), 32'd0);
        apply({32'd7, 32'h0100_0001, 32'hFFFF_FFFF, 32'h8000_0000}, 4'd14, 3'd3, 12'd0, 1'b1, 1'b0);
        check4("R12", 32'hCF00_0000, MONE_F, 32'h4B80_0000, 32'h40E0_0000);
        apply({96'd0, 16'd0, 16'hFFFF}, 4'd2, 3'd3, 12'd0, 1'b1, 1'b0);
        check4("R12", MONE_F, 32'd0, 32'd0, ONE_F);
    endtask

    task automatic t_float;
        apply(128'h4040_0000_BF80_0000_7F80_0001_3F80_0000, 4'd14, 3'd7, 12'd0, 1'b1, 1'b0);
        check4("R13", 32'h3F80_0000, 32'h7F80_0001, 32'hBF80_0000, 32'h4040_0000);
        apply({96'd0, 32'hC0A0_0000}, 4'd4, 3'd7, 12'd0, 1'b1, 1'b0);
        check4("R13", 32'hC0A0_0000, 32'd0, 32'd0, ONE_F);
        apply({96'd0, 32'h4433_2211}, 4'd10, 3'd7, mk_sel(3'd1, 3'd4, 3'd5, 3'd1), 1'b0, 1'b0);
        check4("R13 narrow layout", 0, 0, 0, 0);
        apply({96'd0, 32'h4433_2211}, 4'd5, 3'd7, 12'd0, 1'b1, 1'b0);
        check4("R13 narrow layout", 0, 0, 0, 0);
    endtask

    task automatic t_invalid;
        apply({96'd0, 32'h4433_2211}, 4'd0, 3'd4, 12'd0, 1'b1, 1'b0);
        check4("R14 code 0", 0, 0, 0, 0);
        apply({96'd0, 32'h4433_2211}, 4'd15, 3'd0, mk_sel(3'd1, 3'd1, 3'd1, 3'd1), 1'b0, 1'b0);
        check4("R14 code 15", 0, 0, 0, 0);
    endtask

    task automatic t_hold;
        apply({96'd0, 32'h4433_2211}, 4'd10, 3'd4, 12'd0, 1'b1, 1'b0);
        check("R2", "valid after request", {31'd0, out_valid}, 32'd1);
        in_word = '1; in_dfmt = 4'd14; in_nfmt = 3'd2; in_oob = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R2", "valid idle", {31'd0, out_valid}, 32'd0);
            check4("R2 hold", 32'h11, 32'h22, 32'h33, 32'h44);
        end
        in_oob = 1'b0;
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layouts();
        t_sign_ext();
        t_missing();
        t_select();
        t_identity();
        t_oob();
        t_unorm();
        t_snorm();
        t_snorm_gl();
        t_scaled();
        t_float();
        t_invalid();
        t_hold();
        report();
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

endmodule